// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers of a 16-bit processor. The instruction set addresses eight registers by a 3-bit index: six general registers at indices 0 to 5, the stack pointer at index 6 and the program counter at index 7. Behind these eight indices sit sixteen physical registers.

The six general registers exist in two copies. Bit 11 of the processor status word picks which copy is used. The stack pointer exists in three copies, one each for the kernel, supervisor and user modes. The mode field in bits 15:14 of the status word picks the copy, and bit 11 has no effect on it. The program counter is a single register that every mode and every register set shares.

The block has two asynchronous read ports and one synchronous write port. All three ports decode their index against the same status word input. A mode code that is not defined still selects the kernel stack pointer, and it raises a flag output so the surrounding logic can respond.

Top module: `gpr_bank_file`

## Requirements
- R1: After reset, every physical register reads as zero, whatever the index, register-set bit or mode.
- R2: Indices 0 to 5 address one of two independent copies. The copy is chosen by status bit 11 (0 selects the first copy, 1 the second). A value written to one copy is read back unchanged once that copy is selected again.
- R3: Index 6 addresses a stack pointer chosen by status bits 15:14. The code 00 selects kernel, 01 supervisor and 11 user. Each copy keeps its own value.
- R4: The stack pointer chosen at index 6 does not depend on status bit 11.
- R5: Index 7 addresses one shared program counter. A value written under any mode or register set reads back under every other mode and register set.
- R6: Mode code 10 selects the kernel stack pointer. While bits 15:14 equal 10, `mode_rsvd_o` is 1 in the same cycle; for every other code it is 0.
- R7: A write is committed at the rising clock edge. A read of the same physical register in the cycle of the write returns the old value, and the new value is visible from the next cycle.
- R8: The two read ports are independent. Each returns the register named by its own index, in the same cycle.
- R9: While `wr_en` is 0, no register changes, whatever is applied to `wr_idx` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| psw_i | input | 16 | Status word; bit 11 is the register set, bits 15:14 are the mode |
| ra_idx | input | 3 | Read port A architectural index |
| ra_data | output | 16 | Read port A data |
| rb_idx | input | 3 | Read port B architectural index |
| rb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write architectural index |
| wr_data | input | 16 | Write data |
| mode_rsvd_o | output | 1 | High while the mode field holds the reserved code 10 |

## Verification
Read data and the reserved-mode flag are combinational from the status word, the indices and the stored values. They are therefore due in the same cycle as the stimulus. The bench drives its inputs on the falling edge and samples one nanosecond later, before any rising edge can intervene. A write lands one rising edge after it is presented. Write checks sample at the following falling edge, and the old-value check samples before that edge. Status-word changes between a write and its read-back test that the data followed the physical register and not the index.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
  localparam int unsigned NUM_GPR   = 6;
  localparam int unsigned NUM_SETS  = 2;
  localparam int unsigned NUM_SP    = 3;
  localparam int unsigned NUM_SLOTS = NUM_GPR * NUM_SETS + NUM_SP + 1;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned IDX_W     = 3;
  localparam int unsigned SET_BIT   = 11;
  localparam int unsigned MODE_HI   = 15;
  localparam int unsigned MODE_LO   = 14;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_USER = 2'b11
  } cpu_mode_e;

  localparam logic [IDX_W-1:0] IDX_SP = 3'd6;
  localparam logic [IDX_W-1:0] IDX_PC = 3'd7;

  localparam logic [SLOT_W-1:0] SLOT_KSP = SLOT_W'(NUM_GPR * NUM_SETS);
  localparam logic [SLOT_W-1:0] SLOT_SSP = SLOT_W'(NUM_GPR * NUM_SETS + 1);
  localparam logic [SLOT_W-1:0] SLOT_USP = SLOT_W'(NUM_GPR * NUM_SETS + 2);
  localparam logic [SLOT_W-1:0] SLOT_PC  = SLOT_W'(NUM_SLOTS - 1);
endpackage

// File: rtl/gpr_slot_map.sv
module gpr_slot_map
  import gpr_bank_pkg::*;
(
  input  logic              set_sel,
  input  cpu_mode_e         mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot
);
  always_comb begin
    if (idx == IDX_PC) begin
      slot = SLOT_PC;
    end else if (idx == IDX_SP) begin
      unique case (mode)
        MODE_SUPV: slot = SLOT_SSP;
        MODE_USER: slot = SLOT_USP;
        default:   slot = SLOT_KSP;
      endcase
    end else begin
      slot = SLOT_W'(idx) + (set_sel ? SLOT_W'(NUM_GPR) : SLOT_W'(0));
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import gpr_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot_a,
  input  logic [SLOT_W-1:0] rslot_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] q   [NUM_SLOTS];
  logic [DATA_W-1:0] nxt [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic en;
    assign en = we && (wslot == SLOT_W'(s));

    always_comb begin
      nxt[s] = q[s];
      if (en) nxt[s] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[s] <= '0;
      else        q[s] <= nxt[s];
    end
  end

  assign rdata_a = q[rslot_a];
  assign rdata_b = q[rslot_b];
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
  import gpr_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       psw_i,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_rsvd_o
);
  localparam int unsigned NUM_PORTS = 3;

  cpu_mode_e         cur_mode;
  logic              cur_set;
  logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
  logic [SLOT_W-1:0] port_slot [NUM_PORTS];

  assign cur_mode    = cpu_mode_e'(psw_i[MODE_HI:MODE_LO]);
  assign cur_set     = psw_i[SET_BIT];
  assign mode_rsvd_o = (cur_mode == MODE_RSVD);

  assign port_idx[0] = ra_idx;
  assign port_idx[1] = rb_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    gpr_slot_map u_map (
      .set_sel (cur_set),
      .mode    (cur_mode),
      .idx     (port_idx[p]),
      .slot    (port_slot[p])
    );
  end

  gpr_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .wslot   (port_slot[2]),
    .wdata   (wr_data),
    .rslot_a (port_slot[0]),
    .rslot_b (port_slot[1]),
    .rdata_a (ra_data),
    .rdata_b (rb_data)
  );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       psw_i,
  input logic [2:0]        ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic              wr_en,
  input logic [2:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data
);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!($stable(psw_i) && $stable(ra_idx)) || $stable(ra_data)));

  // R7
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!($stable(psw_i) && ra_idx == $past(wr_idx)) || ra_data == $past(wr_data)));

  // R5
  pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd7) |=> (ra_idx != 3'd7 || ra_data == $past(wr_data)));

  // R6
  rsvd_ksp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd6 && psw_i[15:14] == 2'b00)
      |=> (!(psw_i[15:14] == 2'b10 && ra_idx == 3'd6) || ra_data == $past(wr_data)));
endmodule

bind gpr_bank_file gpr_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psw_i   (psw_i),
  .ra_idx  (ra_idx),
  .ra_data (ra_data),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_data (wr_data)
);

// File: tb/tb_gpr_bank_file.sv
`timescale 1ns/1ps
module tb_gpr_bank_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] psw_i;
  logic [2:0]  ra_idx, rb_idx, wr_idx;
  logic [15:0] ra_data, rb_data, wr_data;
  logic        wr_en;
  logic        mode_rsvd_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  gpr_bank_file dut (
    .clk(clk), .rst_n(rst_n), .psw_i(psw_i),
    .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode_rsvd_o(mode_rsvd_o)
  );

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] p, input logic [2:0] i, input logic [15:0] d);
    @(negedge clk);
    psw_i = p; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [15:0] p, input logic [2:0] i, input logic [15:0] exp);
    psw_i = p; ra_idx = i; rb_idx = i;
    #1;
    cmp({tag, " port A"}, ra_data, exp);
    cmp({tag, " port B"}, rb_data, exp);
  endtask

  task automatic t_reset;
    logic [15:0] psws [5];
    psws = '{16'h0000, 16'h0800, 16'h4000, 16'hC800, 16'h8000};
    rst_n = 1'b0; wr_en = 1'b0; psw_i = '0;
    ra_idx = '0; rb_idx = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    foreach (psws[k])
      for (int i = 0; i < 8; i++) rd("R1 reset zero", psws[k], 3'(i), 16'h0000);
  endtask

  task automatic t_banks;
    for (int i = 0; i < 6; i++) wr(16'h0000, 3'(i), 16'h0100 + 16'(i));
    for (int i = 0; i < 6; i++) wr(16'hC800, 3'(i), 16'h1100 + 16'(i));
    @(negedge clk);
    for (int i = 0; i < 6; i++) rd("R2 set0 kept", 16'h4000, 3'(i), 16'h0100 + 16'(i));
    for (int i = 0; i < 6; i++) rd("R2 set1 kept", 16'h0800, 3'(i), 16'h1100 + 16'(i));
  endtask

  task automatic t_sp;
    wr(16'h0000, 3'd6, 16'hA000);
    wr(16'h4800, 3'd6, 16'hB000);
    wr(16'hC000, 3'd6, 16'hC000);
    @(negedge clk);
    rd("R3 ksp", 16'h0000, 3'd6, 16'hA000);
    rd("R3 ssp", 16'h4000, 3'd6, 16'hB000);
    rd("R3 usp", 16'hC000, 3'd6, 16'hC000);
    rd("R4 ksp set1", 16'h0800, 3'd6, 16'hA000);
    rd("R4 ssp set0", 16'h4000, 3'd6, 16'hB000);
    rd("R4 usp set1", 16'hC800, 3'd6, 16'hC000);
  endtask

  task automatic t_pc;
    wr(16'h4800, 3'd7, 16'h2106);
    @(negedge clk);
    rd("R5 pc kern", 16'h0000, 3'd7, 16'h2106);
    rd("R5 pc user", 16'hC000, 3'd7, 16'h2106);
    rd("R5 pc rsvd set1", 16'h8800, 3'd7, 16'h2106);
  endtask

  task automatic t_rsvd;
    @(negedge clk);
    rd("R6 rsvd reads ksp", 16'h8000, 3'd6, 16'hA000);
    cmp("R6 flag high", {15'b0, mode_rsvd_o}, 16'h0001);
    rd("R6 user not rsvd", 16'hC000, 3'd6, 16'hC000);
    cmp("R6 flag low user", {15'b0, mode_rsvd_o}, 16'h0000);
    rd("R6 supv not rsvd", 16'h4000, 3'd6, 16'hB000);
    cmp("R6 flag low supv", {15'b0, mode_rsvd_o}, 16'h0000);
    wr(16'h8800, 3'd6, 16'hA5A5);
    @(negedge clk);
    rd("R6 rsvd wrote ksp", 16'h0000, 3'd6, 16'hA5A5);
    rd("R6 rsvd set1 r0", 16'h8800, 3'd0, 16'h1100);
  endtask

  task automatic t_timing;
    @(negedge clk);
    psw_i = 16'h0000; wr_idx = 3'd1; wr_data = 16'h7777; wr_en = 1'b1; ra_idx = 3'd1;
    #1;
    cmp("R7 old value in write cycle", ra_data, 16'h0101);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    cmp("R7 new value next cycle", ra_data, 16'h7777);
  endtask

  task automatic t_nowe;
    @(negedge clk);
    psw_i = 16'h0000; wr_en = 1'b0; wr_idx = 3'd2; wr_data = 16'hFFFF;
    repeat (2) @(negedge clk);
    rd("R9 no write when disabled", 16'h0000, 3'd2, 16'h0102);
    rd("R9 pc untouched", 16'h0000, 3'd7, 16'h2106);
  endtask

  task automatic t_ports;
    @(negedge clk);
    psw_i = 16'h0800; ra_idx = 3'd3; rb_idx = 3'd7;
    #1;
    cmp("R8 port A r3 set1", ra_data, 16'h1103);
    cmp("R8 port B pc", rb_data, 16'h2106);
    ra_idx = 3'd6; rb_idx = 3'd0;
    #1;
    cmp("R8 port A ksp", ra_data, 16'hA5A5);
    cmp("R8 port B r0 set1", rb_data, 16'h1100);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_banks();
    t_sp();
    t_pc();
    t_rsvd();
    t_timing();
    t_nowe();
    t_ports();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule